// File: doc/BRIEF.md
# Stream-to-Memory Descriptor Write-Back Engine

This block is the receive half of a DMA channel that works through a linked list of descriptors held in memory. It loads one descriptor at a time and stores incoming stream bytes into that descriptor's buffer until the buffer is full or the packet ends. It then writes a status word back into the descriptor and moves to the next descriptor through the link pointer. A packet larger than one buffer continues into the following descriptors. A separate side-channel stream delivers five application words for each packet. The engine holds them and copies them into the descriptor that receives the packet's final byte.

Run control and interrupt handling sit outside this block. The block receives a run level, a start pulse that loads the first descriptor pointer, and a tail pointer with a kick pulse. It reports halted, idle, the current descriptor pointer and a one-cycle completion pulse. Memory is a single word-addressed port with a request/grant handshake. Read data arrives in the cycle after a granted read.

Top module: `s2m_desc_engine`

## Requirements
- R1: After reset, halted is 1, idle is 0, s_tready is 0, done_pulse is 0 and no memory request is made. The start-of-frame flag is 1, so the first descriptor filled after reset reports start-of-frame.
- R2: s_tready is 1 only while run is 1, idle is 0 and halted is 0. While s_tready is 0, no beat is taken.
- R3: The descriptor layout, in 32-bit words from its base, is: word 0 next pointer, word 1 buffer address, word 2 control (byte capacity in bits 22:0, upper bits ignored), word 3 status, words 4..8 application words. Capacity is a whole number of words. Byte n of a descriptor's data goes to buffer word n/4, byte lane n%4. Each beat is written with byte strobes equal to s_tkeep, which holds contiguous low lanes (lane 0 = bits 7:0) and is partial only on the last beat. A descriptor takes at most its capacity, and the following beats go to the next descriptor.
- R4: Every written-back status word has bit 31 set, bit 27 = start-of-frame, bit 26 = end-of-frame, bits 22:0 = bytes received, and all other bits 0.
- R5: Start-of-frame for a descriptor equals the end-of-frame of the previous written-back descriptor.
- R6: The side channel carries five words per packet. They are latched in arrival order, restarting after the fifth word or a word marked last. Only the descriptor that took the beat with s_tlast gets them, written to words 4..8 in order. Other descriptors' words 4..8 are left unchanged.
- R7: done_pulse is high for exactly one cycle for each descriptor written back with end-of-frame.
- R8: If a fetched descriptor already has status bit 31 set, halted rises, cur_ptr stays on that descriptor, nothing is written to memory and no beat is taken.
- R9: After write-back, cur_ptr becomes the descriptor's next pointer. If the written descriptor's address equals tail_in, idle rises. A tail_kick pulse clears idle and the engine resumes at cur_ptr. A ch_start pulse, taken while the engine waits between descriptors, loads cur_in and clears halted and idle.
- R10: A descriptor with capacity 0 is written back at once with count 0, end-of-frame 0 and no data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Channel run level |
| ch_start | input | 1 | Load cur_in and clear halted/idle (while waiting) |
| cur_in | input | AW | First descriptor address |
| tail_in | input | AW | Tail descriptor address |
| tail_kick | input | 1 | Tail updated; clears idle |
| s_tvalid | input | 1 | Data beat valid |
| s_tready | output | 1 | Data beat accepted |
| s_tdata | input | 32 | Data beat, lane 0 in bits 7:0 |
| s_tkeep | input | 4 | Byte lanes present |
| s_tlast | input | 1 | Final beat of packet |
| a_tvalid | input | 1 | Side-channel word valid |
| a_tdata | input | 32 | Side-channel application word |
| a_tlast | input | 1 | Final side-channel word |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Write (1) or read (0) |
| mem_addr | output | AW | Word address |
| mem_wdata | output | 32 | Write data |
| mem_wstrb | output | 4 | Write byte strobes |
| mem_gnt | input | 1 | Request granted this cycle |
| mem_rdata | input | 32 | Read data, cycle after read grant |
| cur_ptr | output | AW | Current descriptor address |
| halted | output | 1 | Halted on a completed descriptor or after reset |
| idle | output | 1 | Tail descriptor written back |
| done_pulse | output | 1 | End-of-frame descriptor written back |

## Verification
The hardest case to reach is a descriptor that starts without start-of-frame. It needs a chain that stops in the middle of a packet. The bench sets the tail to the first descriptor and sends a packet longer than that buffer. The sender stalls on s_tready while the engine sits idle. The bench then adds a second descriptor with tail_kick and checks that the remainder arrives with start-of-frame clear. A second case uses a zero-capacity descriptor to carry a clear flag forward. A sweep of all packet lengths against three buffer sizes covers every way of splitting a packet.

// File: rtl/s2m_pkg.sv
package s2m_pkg;
  localparam int LEN_W     = 23;
  localparam int OFS_NEXT  = 0;
  localparam int OFS_BUF   = 1;
  localparam int OFS_CTRL  = 2;
  localparam int OFS_STAT  = 3;
  localparam int OFS_APP   = 4;
  localparam int BIT_CPLT  = 31;
  localparam int BIT_SOF   = 27;
  localparam int BIT_EOF   = 26;

  typedef enum logic [2:0] {
    ST_WAIT, ST_FREQ, ST_FDATA, ST_RECV, ST_DWR, ST_AWR, ST_SWR, ST_ADV
  } eng_state_t;

  function automatic logic [2:0] keep_bytes(input logic [3:0] k);
    return 3'(k[0]) + 3'(k[1]) + 3'(k[2]) + 3'(k[3]);
  endfunction

  function automatic logic [31:0] make_status(input logic sof, input logic eof,
                                              input logic [LEN_W-1:0] cnt);
    logic [31:0] w;
    w = '0;
    w[BIT_CPLT] = 1'b1;
    w[BIT_SOF]  = sof;
    w[BIT_EOF]  = eof;
    w[LEN_W-1:0] = cnt;
    return w;
  endfunction
endpackage

// File: rtl/s2m_app_latch.sv
module s2m_app_latch #(
  parameter int APP_WORDS = 5,
  localparam int IW = (APP_WORDS > 1) ? $clog2(APP_WORDS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [31:0]   in_word,
  input  logic          in_last,
  input  logic [IW-1:0] rd_idx,
  output logic [31:0]   rd_word
);
  logic [31:0]   words [APP_WORDS];
  logic [IW-1:0] wr_idx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_idx <= '0;
      for (int i = 0; i < APP_WORDS; i++) words[i] <= '0;
    end else if (in_valid) begin
      words[wr_idx] <= in_word;
      wr_idx <= (in_last || wr_idx == IW'(APP_WORDS - 1)) ? '0 : wr_idx + 1'b1;
    end
  end

  assign rd_word = words[rd_idx];
endmodule

// File: rtl/s2m_byte_tally.sv
module s2m_byte_tally
  import s2m_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             add,
  input  logic [3:0]       keep,
  input  logic [LEN_W-1:0] cap,
  output logic [LEN_W-1:0] cnt,
  output logic             fills
);
  logic [LEN_W-1:0] cnt_next;

  assign cnt_next = cnt + LEN_W'(keep_bytes(keep));
  assign fills    = (cnt_next >= cap);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) cnt <= '0;
    else if (add)      cnt <= cnt_next;
  end
endmodule

// File: rtl/s2m_desc_engine.sv
module s2m_desc_engine
  import s2m_pkg::*;
#(
  parameter int AW        = 16,
  parameter int APP_WORDS = 5,
  localparam int IW = (APP_WORDS > 1) ? $clog2(APP_WORDS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          ch_start,
  input  logic [AW-1:0] cur_in,
  input  logic [AW-1:0] tail_in,
  input  logic          tail_kick,
  input  logic          s_tvalid,
  output logic          s_tready,
  input  logic [31:0]   s_tdata,
  input  logic [3:0]    s_tkeep,
  input  logic          s_tlast,
  input  logic          a_tvalid,
  input  logic [31:0]   a_tdata,
  input  logic          a_tlast,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  output logic [3:0]    mem_wstrb,
  input  logic          mem_gnt,
  input  logic [31:0]   mem_rdata,
  output logic [AW-1:0] cur_ptr,
  output logic          halted,
  output logic          idle,
  output logic          done_pulse
);
  eng_state_t       st;
  logic [AW-1:0]    cur_q, next_q, buf_q;
  logic [LEN_W-1:0] cap_q, cnt;
  logic [1:0]       fidx;
  logic [IW-1:0]    aidx;
  logic             sof_q, eop_q, halted_q, idle_q;
  logic [31:0]      hold_data;
  logic [3:0]       hold_keep;
  logic             hold_last;
  logic [31:0]      app_word;
  logic             fills;
  logic             rd_unused;

  // named events for the checker
  logic go, beat_acc, data_fire, app_fire, status_fire, fetch_end;
  assign go          = run && !idle_q && !halted_q;
  assign s_tready    = (st == ST_RECV) && go;
  assign beat_acc    = s_tvalid && s_tready;
  assign data_fire   = (st == ST_DWR) && mem_gnt;
  assign app_fire    = (st == ST_AWR) && mem_gnt;
  assign status_fire = (st == ST_SWR) && mem_gnt;
  assign fetch_end   = (st == ST_FDATA) && (fidx == 2'd3);
  assign rd_unused   = ^mem_rdata;

  s2m_app_latch #(.APP_WORDS(APP_WORDS)) u_app (
    .clk(clk), .rst_n(rst_n), .in_valid(a_tvalid), .in_word(a_tdata),
    .in_last(a_tlast), .rd_idx(aidx), .rd_word(app_word)
  );

  s2m_byte_tally u_tally (
    .clk(clk), .rst_n(rst_n), .clr(st == ST_FDATA), .add(data_fire),
    .keep(hold_keep), .cap(cap_q), .cnt(cnt), .fills(fills)
  );

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = cur_q;
    mem_wdata = '0;
    mem_wstrb = '0;
    case (st)
      ST_FREQ: begin
        mem_req  = 1'b1;
        mem_addr = cur_q + AW'(fidx);
      end
      ST_DWR: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = buf_q + AW'(cnt >> 2);
        mem_wdata = hold_data;
        mem_wstrb = hold_keep;
      end
      ST_AWR: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = cur_q + AW'(OFS_APP) + AW'(aidx);
        mem_wdata = app_word;
        mem_wstrb = 4'hF;
      end
      ST_SWR: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = cur_q + AW'(OFS_STAT);
        mem_wdata = make_status(sof_q, eop_q, cnt);
        mem_wstrb = 4'hF;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_WAIT;
      cur_q     <= '0;
      next_q    <= '0;
      buf_q     <= '0;
      cap_q     <= '0;
      fidx      <= '0;
      aidx      <= '0;
      sof_q     <= 1'b1;
      eop_q     <= 1'b0;
      halted_q  <= 1'b1;
      idle_q    <= 1'b0;
      hold_data <= '0;
      hold_keep <= '0;
      hold_last <= 1'b0;
    end else begin
      case (st)
        ST_WAIT: begin
          if (ch_start) begin
            cur_q    <= cur_in;
            halted_q <= 1'b0;
            idle_q   <= 1'b0;
          end else if (go) begin
            fidx <= '0;
            st   <= ST_FREQ;
          end
        end
        ST_FREQ: if (mem_gnt) st <= ST_FDATA;
        ST_FDATA: begin
          case (fidx)
            2'd0:    next_q <= mem_rdata[AW-1:0];
            2'd1:    buf_q  <= mem_rdata[AW-1:0];
            2'd2:    cap_q  <= mem_rdata[LEN_W-1:0];
            default: ;
          endcase
          if (fetch_end) begin
            if (mem_rdata[BIT_CPLT]) begin
              halted_q <= 1'b1;
              st       <= ST_WAIT;
            end else begin
              eop_q <= 1'b0;
              st    <= (cap_q == '0) ? ST_SWR : ST_RECV;
            end
          end else begin
            fidx <= fidx + 2'd1;
            st   <= ST_FREQ;
          end
        end
        ST_RECV: begin
          if (beat_acc) begin
            hold_data <= s_tdata;
            hold_keep <= s_tkeep;
            hold_last <= s_tlast;
            st        <= ST_DWR;
          end
        end
        ST_DWR: begin
          if (mem_gnt) begin
            eop_q <= hold_last;
            if (hold_last) begin
              aidx <= '0;
              st   <= ST_AWR;
            end else if (fills) begin
              st <= ST_SWR;
            end else begin
              st <= ST_RECV;
            end
          end
        end
        ST_AWR: begin
          if (mem_gnt) begin
            if (aidx == IW'(APP_WORDS - 1)) st <= ST_SWR;
            else aidx <= aidx + 1'b1;
          end
        end
        ST_SWR: if (mem_gnt) st <= ST_ADV;
        ST_ADV: begin
          cur_q <= next_q;
          sof_q <= eop_q;
          if (cur_q == tail_in) idle_q <= 1'b1;
          st <= ST_WAIT;
        end
        default: st <= ST_WAIT;
      endcase
      if (tail_kick) idle_q <= 1'b0;
    end
  end

  assign cur_ptr    = cur_q;
  assign halted     = halted_q;
  assign idle       = idle_q;
  assign done_pulse = (st == ST_ADV) && eop_q;
endmodule

// File: rtl/s2m_desc_chk.sv
module s2m_desc_chk
  import s2m_pkg::*;
#(
  parameter int AW = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run,
  input logic             s_tready,
  input logic             halted,
  input logic             idle,
  input logic             done_pulse,
  input logic             mem_req,
  input logic             mem_we,
  input logic             mem_gnt,
  input logic [AW-1:0]    mem_addr,
  input logic [31:0]      mem_wdata,
  input logic             status_fire,
  input logic             app_fire,
  input logic             data_fire,
  input logic             pkt_end,
  input logic [LEN_W-1:0] cnt,
  input logic [LEN_W-1:0] cap
);
  // R2
  ready_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s_tready |-> (run && !idle && !halted));

  // R4
  cplt_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status_fire |-> (mem_we && mem_wdata[BIT_CPLT]));

  // R6
  app_on_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    app_fire |-> pkt_end);

  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |=> !done_pulse);

  // R3
  fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_fire |-> (cnt < cap));

  // R3
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  // R8
  halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !(mem_req && mem_we));
endmodule

bind s2m_desc_engine s2m_desc_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .s_tready(s_tready),
  .halted(halted), .idle(idle), .done_pulse(done_pulse),
  .mem_req(mem_req), .mem_we(mem_we), .mem_gnt(mem_gnt),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata),
  .status_fire(status_fire), .app_fire(app_fire), .data_fire(data_fire),
  .pkt_end(hold_last), .cnt(cnt), .cap(cap_q)
);

// File: tb/s2m_desc_engine_bench.sv
module s2m_desc_engine_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic rst_n = 1'b0, run = 1'b0, ch_start = 1'b0, tail_kick = 1'b0;
  logic [AW-1:0] cur_in = '0, tail_in = '0;
  logic s_tvalid = 1'b0, s_tlast = 1'b0, a_tvalid = 1'b0, a_tlast = 1'b0;
  logic [31:0] s_tdata = '0, a_tdata = '0;
  logic [3:0] s_tkeep = '0;
  logic s_tready, mem_req, mem_we, halted, idle, done_pulse, mem_gnt;
  logic [AW-1:0] mem_addr, cur_ptr;
  logic [31:0] mem_wdata, mem_rdata;
  logic [3:0] mem_wstrb;

  s2m_desc_engine #(.AW(AW), .APP_WORDS(5)) u_s2m_desc_engine (
    .clk(clk), .rst_n(rst_n), .run(run), .ch_start(ch_start), .cur_in(cur_in),
    .tail_in(tail_in), .tail_kick(tail_kick), .s_tvalid(s_tvalid),
    .s_tready(s_tready), .s_tdata(s_tdata), .s_tkeep(s_tkeep), .s_tlast(s_tlast),
    .a_tvalid(a_tvalid), .a_tdata(a_tdata), .a_tlast(a_tlast),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_wstrb(mem_wstrb), .mem_gnt(mem_gnt),
    .mem_rdata(mem_rdata), .cur_ptr(cur_ptr), .halted(halted), .idle(idle),
    .done_pulse(done_pulse)
  );

  // memory model with a stalling grant and a bench host write port
  logic [31:0] mem [0:1023];
  logic [31:0] rdata_q = '0;
  logic [1:0]  scnt = '0;
  logic        hw_en = 1'b0;
  logic [9:0]  hw_addr = '0;
  logic [31:0] hw_data = '0;
  assign mem_gnt   = mem_req && (scnt != 2'd3);
  assign mem_rdata = rdata_q;

  always @(posedge clk) begin
    scnt <= scnt + 2'd1;
    if (hw_en) mem[hw_addr] <= hw_data;
    else if (mem_req && mem_gnt) begin
      if (mem_we) begin
        for (int j = 0; j < 4; j++)
          if (mem_wstrb[j]) mem[mem_addr[9:0]][8*j +: 8] <= mem_wdata[8*j +: 8];
      end else rdata_q <= mem[mem_addr[9:0]];
    end
  end

  int n_vec = 0, n_bad = 0, done_cnt = 0, pk = 0;
  always @(negedge clk) if (done_pulse) done_cnt++;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int da(input int d); return 'h100 + 16*d; endfunction
  function automatic int ba(input int d); return 'h200 + 16*d; endfunction
  function automatic logic [7:0] pb(input int p, input int i);
    return 8'(p*29 + i*7 + 3);
  endfunction
  function automatic logic [31:0] app_w(input int p, input int j);
    return {16'(p), 8'hA0, 8'(j)};
  endfunction
  function automatic logic [31:0] exp_stat(input int sof, input int eof, input int n);
    return 32'h8000_0000 + 32'(sof)*32'h0800_0000 + 32'(eof)*32'h0400_0000 + 32'(n);
  endfunction

  task automatic hwr(input int a, input logic [31:0] d);
    hw_en = 1'b1; hw_addr = 10'(a); hw_data = d;
    @(negedge clk);
    hw_en = 1'b0;
  endtask

  task automatic setup_desc(input int d, input int cap, input logic [31:0] st0);
    hwr(da(d) + 0, 32'(da(d + 1)));
    hwr(da(d) + 1, 32'(ba(d)));
    hwr(da(d) + 2, 32'hFF80_0000 | 32'(cap));
    hwr(da(d) + 3, st0);
    for (int j = 0; j < 5; j++) hwr(da(d) + 4 + j, 32'h0);
    for (int w = 0; w < 4; w++) hwr(ba(d) + w, 32'h0);
  endtask

  task automatic pulse_start(input int d);
    cur_in = AW'(da(d)); ch_start = 1'b1;
    @(negedge clk);
    ch_start = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 3000 && !idle; i++) @(negedge clk);
    if (!idle) chk("R9 idle timeout", 32'(idle), 32'd1);
  endtask

  task automatic send_packet(input int p, input int len);
    int nb;
    for (int j = 0; j < 5; j++) begin
      a_tvalid = 1'b1; a_tdata = app_w(p, j); a_tlast = (j == 4);
      @(negedge clk);
    end
    a_tvalid = 1'b0; a_tlast = 1'b0;
    nb = (len + 3) / 4;
    for (int b = 0; b < nb; b++) begin
      logic [31:0] w;
      logic [3:0]  k;
      for (int j = 0; j < 4; j++) begin
        if (4*b + j < len) begin w[8*j +: 8] = pb(p, 4*b + j); k[j] = 1'b1; end
        else begin w[8*j +: 8] = 8'hEE; k[j] = 1'b0; end
      end
      s_tvalid = 1'b1; s_tdata = w; s_tkeep = k; s_tlast = (b == nb - 1);
      while (!s_tready) @(negedge clk);
      @(negedge clk);
    end
    s_tvalid = 1'b0; s_tlast = 1'b0;
  endtask

  // expected buffer word: bytes at offset base within packet p, limited to cnt bytes
  function automatic logic [31:0] exp_buf(input int p, input int base, input int w, input int cnt);
    logic [31:0] e = '0;
    for (int j = 0; j < 4; j++)
      if (4*w + j < cnt) e[8*j +: 8] = pb(p, base + 4*w + j);
    return e;
  endfunction

  task automatic run_pkt(input int cap, input int len);
    int n, d0, c;
    n = (len + cap - 1) / cap;
    for (int d = 0; d < n; d++) setup_desc(d, cap, 32'h0);
    tail_in = AW'(da(n - 1));
    pulse_start(0);
    d0 = done_cnt;
    send_packet(pk, len);
    wait_idle();
    for (int d = 0; d < n; d++) begin
      c = (len - d*cap > cap) ? cap : len - d*cap;
      chk("R4 R5 status", mem[da(d) + 3], exp_stat(d == 0, d == n - 1, c));
      for (int j = 0; j < 5; j++)
        chk("R6 app", mem[da(d) + 4 + j], (d == n - 1) ? app_w(pk, j) : 32'h0);
      for (int w = 0; w < cap/4; w++)
        chk("R3 buffer", mem[ba(d) + w], exp_buf(pk, d*cap, w, c));
    end
    chk("R9 cur_ptr", 32'(cur_ptr), 32'(da(n)));
    chk("R7 done count", 32'(done_cnt - d0), 32'd1);
    pk++;
  endtask

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_vec++; n_bad++;
    $display("FAIL R9 watchdog actual=hung expected=finished");
    finish_run();
  end

  initial begin
    int d0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1; run = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 halted", 32'(halted), 32'd1);
    chk("R1 idle", 32'(idle), 32'd0);
    chk("R1 ready", 32'(s_tready), 32'd0);
    chk("R1 done", 32'(done_pulse), 32'd0);
    chk("R1 mem_req", 32'(mem_req), 32'd0);

    // sweep of packet length against buffer capacity (R3 R4 R5 R6 R7 R9)
    for (int ci = 1; ci <= 3; ci++)
      for (int len = 1; len <= 16*ci; len++) run_pkt(4*ci, len);

    // mid-packet tail: second descriptor starts without start-of-frame (R5 R9 R2)
    setup_desc(0, 8, 32'h0);
    setup_desc(1, 8, 32'h0);
    tail_in = AW'(da(0));
    pulse_start(0);
    d0 = done_cnt;
    fork
      send_packet(pk, 12);
      begin
        wait_idle();
        repeat (3) @(negedge clk);
        chk("R5 first part", mem[da(0) + 3], exp_stat(1, 0, 8));
        chk("R2 ready while idle", 32'(s_tready), 32'd0);
        chk("R9 cur after tail", 32'(cur_ptr), 32'(da(1)));
        chk("R7 no done yet", 32'(done_cnt - d0), 32'd0);
        tail_in = AW'(da(1)); tail_kick = 1'b1;
        @(negedge clk);
        tail_kick = 1'b0;
      end
    join
    wait_idle();
    chk("R5 continuation", mem[da(1) + 3], exp_stat(0, 1, 4));
    chk("R6 app final", mem[da(1) + 4], app_w(pk, 0));
    chk("R6 app not first", mem[da(0) + 8], 32'h0);
    chk("R3 spill word", mem[ba(1)], exp_buf(pk, 8, 0, 4));
    chk("R7 done once", 32'(done_cnt - d0), 32'd1);
    pk++;

    // zero-capacity descriptor (R10 R5)
    setup_desc(0, 0, 32'h0);
    setup_desc(1, 8, 32'h0);
    tail_in = AW'(da(1));
    pulse_start(0);
    d0 = done_cnt;
    send_packet(pk, 4);
    wait_idle();
    chk("R10 zero cap status", mem[da(0) + 3], exp_stat(1, 0, 0));
    chk("R10 zero cap buffer", mem[ba(0)], 32'h0);
    chk("R5 after zero cap", mem[da(1) + 3], exp_stat(0, 1, 4));
    chk("R7 done zero cap", 32'(done_cnt - d0), 32'd1);
    pk++;

    // already-complete descriptor halts (R8)
    setup_desc(0, 8, 32'h8000_0000);
    tail_in = AW'(da(0));
    pulse_start(0);
    s_tvalid = 1'b1; s_tdata = 32'h1234_5678; s_tkeep = 4'hF; s_tlast = 1'b1;
    repeat (30) @(negedge clk);
    chk("R8 halted", 32'(halted), 32'd1);
    chk("R8 ready low", 32'(s_tready), 32'd0);
    chk("R8 cur held", 32'(cur_ptr), 32'(da(0)));
    chk("R8 status kept", mem[da(0) + 3], 32'h8000_0000);
    chk("R8 buffer untouched", mem[ba(0)], 32'h0);
    s_tvalid = 1'b0; s_tlast = 1'b0;

    // run low keeps stream stalled (R2), then resumes with start-of-frame (R5)
    hwr(da(0) + 3, 32'h0);
    run = 1'b0;
    pulse_start(0);
    s_tvalid = 1'b1;
    repeat (20) @(negedge clk);
    chk("R2 run low ready", 32'(s_tready), 32'd0);
    chk("R9 start clears halt", 32'(halted), 32'd0);
    chk("R2 run low buffer", mem[ba(0)], 32'h0);
    s_tvalid = 1'b0;
    run = 1'b1;
    d0 = done_cnt;
    send_packet(pk, 4);
    wait_idle();
    chk("R5 resume status", mem[da(0) + 3], exp_stat(1, 1, 4));
    chk("R3 resume data", mem[ba(0)], exp_buf(pk, 0, 0, 4));
    chk("R7 resume done", 32'(done_cnt - d0), 32'd1);
    finish_run();
  end
endmodule